// File: doc/BRIEF.md
# IQ Mismatch Coefficient Estimator

This block estimates receive-path I/Q imbalance correction values for several receive chains. After a start pulse it adds up, for every chain, the I-branch power, the Q-branch power and the signed I/Q cross-correlation words that a measurement engine presents with a valid strobe. It stops after a programmed number of rounds.

Once the rounds are gathered, the block visits each chain enabled in the receive chain mask. For each one it derives two denominators from the power sums. It then runs two divisions on a single shared restoring divider, one division at a time. From the quotients it forms a 6-bit I coefficient and a saturated signed 5-bit Q coefficient. A chain whose statistics would give a zero denominator keeps its previous coefficients.

When every chain has been visited, the block raises a global correction-enable output and pulses done. Software or a writeback stage then copies the coefficients into the correction datapath.

Top module: `iqcal_coef_est`

## Requirements
- R1: A `start` pulse while idle clears all accumulators and latches `sample_target`. Each cycle with `meas_valid` high during accumulation then adds every chain's `meas_pwr_i`, `meas_pwr_q` and `meas_corr` words into 32-bit sums that wrap modulo 2^32. Accumulation ends once the number of accepted rounds equals `sample_target`. A target of 0 accepts no rounds, and valid cycles after the last round are ignored.
- R2: An accumulated correlation strictly greater than 0x80000000 is negative, and its magnitude is its two's complement. A correlation equal to 0x80000000 or below counts as non-negative, and its magnitude is the value itself.
- R3: The I denominator is ((Ipow>>1) + (Qpow>>1)) >> 7 and the Q denominator is Qpow >> 6, computed from the chain's accumulated sums.
- R4: When Qpow, the I denominator or the Q denominator is zero, the chain's coefficients and its updated flag are left unchanged.
- R5: The I coefficient is (magnitude / I denominator) mod 64 when the correlation is negative. Otherwise it is (64 - that value) mod 64. Chain c occupies `coef_i[6c+5:6c]`.
- R6: The Q coefficient is (Ipow / Q denominator) - 64, saturated to the range -16..+15 and given as 5-bit two's complement in `coef_q[5c+4:5c]`.
- R7: Only chains whose bit c of `chain_mask` (sampled at start) is 1 are processed. The coefficients of the other chains keep their values.
- R8: `corr_en` is cleared by `start`, stays low while busy, and is set in the cycle `done` pulses.
- R9: `busy` is high from the cycle after an accepted `start` until the run ends. `done` is a single-cycle pulse in the first cycle with `busy` low again.
- R10: `coef_upd` is cleared by `start`, and bit c is set when chain c receives new coefficients. Bits never clear otherwise.
- R11: While idle, `coef_i` and `coef_q` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new estimation run (accepted when idle) |
| chain_mask | input | NCH | Chains to process |
| sample_target | input | CNT_W | Number of measurement rounds |
| meas_valid | input | 1 | One measurement round present |
| meas_pwr_i | input | NCH*DW | Per-chain I power words |
| meas_pwr_q | input | NCH*DW | Per-chain Q power words |
| meas_corr | input | NCH*DW | Per-chain signed I/Q correlation words |
| busy | output | 1 | Run in progress |
| done | output | 1 | End-of-run pulse |
| corr_en | output | 1 | Global IQ correction enable |
| coef_upd | output | NCH | Chain received new coefficients this run |
| coef_i | output | NCH*6 | Per-chain I coefficients |
| coef_q | output | NCH*5 | Per-chain signed Q coefficients |

## Verification
`busy` rises and `corr_en` falls one clock edge after the start edge, so the bench samples them at the next falling edge. A measurement round counts in the cycle its valid strobe is high, starting at the first falling edge after start. Each enabled chain then takes two divisions of DW+2 cycles plus a setup cycle, while a skipped chain takes one cycle. Because the finishing time depends on the mask and the skip decisions, the bench polls `done` at each falling edge up to a bounded limit. It reads all coefficients, flags and `corr_en` in that same `done` cycle, and confirms one edge later that the pulse has ended.

// File: rtl/iqcal_pkg.sv
package iqcal_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACC,
    ST_SETUP,
    ST_DIV_I,
    ST_DIV_Q,
    ST_FIN
  } est_state_t;

  localparam int COEF_I_W = 6;
  localparam int COEF_Q_W = 5;
  localparam int DEN_I_SHIFT = 7;
  localparam int DEN_Q_SHIFT = 6;
  localparam int Q_BIAS = 64;
  localparam int Q_MAX = 15;
  localparam int Q_MIN = -16;

endpackage

// File: rtl/iqcal_div.sv
module iqcal_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quot,
  output logic         fin
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, quo_q, dvs_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic [W:0]    shifted, trial;
  logic          fits;

  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    trial   = shifted - {1'b0, dvs_q};
    fits    = ~trial[W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      fin   <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        rem_q <= '0;
        quo_q <= dividend;
        dvs_q <= divisor;
        cnt_q <= CW'(W);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= fits ? trial[W-1:0] : shifted[W-1:0];
        quo_q <= {quo_q[W-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q <= 1'b0;
          fin   <= 1'b1;
        end
      end
    end
  end

  assign quot = quo_q;
endmodule

// File: rtl/iqcal_accum.sv
module iqcal_accum #(
  parameter int NCH = 3,
  parameter int DW  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              add,
  input  logic [NCH*DW-1:0] in_pi,
  input  logic [NCH*DW-1:0] in_pq,
  input  logic [NCH*DW-1:0] in_cr,
  output logic [DW-1:0]     sum_pi [NCH],
  output logic [DW-1:0]     sum_pq [NCH],
  output logic [DW-1:0]     sum_cr [NCH]
);
  for (genvar c = 0; c < NCH; c++) begin : g_chain
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        sum_pi[c] <= '0;
        sum_pq[c] <= '0;
        sum_cr[c] <= '0;
      end else if (add) begin
        sum_pi[c] <= sum_pi[c] + in_pi[c*DW +: DW];
        sum_pq[c] <= sum_pq[c] + in_pq[c*DW +: DW];
        sum_cr[c] <= sum_cr[c] + in_cr[c*DW +: DW];
      end
    end
  end
endmodule

// File: rtl/iqcal_coef_fmt.sv
module iqcal_coef_fmt
  import iqcal_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0]         quot_i,
  input  logic [DW-1:0]         quot_q,
  input  logic                  neg,
  output logic [COEF_I_W-1:0]   ci,
  output logic [COEF_Q_W-1:0]   cq
);
  logic [COEF_I_W-1:0] low_i;
  logic signed [DW+1:0] q_biased;

  always_comb begin
    low_i = quot_i[COEF_I_W-1:0];
    ci    = neg ? low_i : (COEF_I_W'(0) - low_i);
    q_biased = $signed({2'b00, quot_q}) - (DW+2)'(Q_BIAS);
    if (q_biased > (DW+2)'(Q_MAX))
      cq = COEF_Q_W'(Q_MAX);
    else if (q_biased < $signed((DW+2)'(Q_MIN)))
      cq = COEF_Q_W'(Q_MIN);
    else
      cq = q_biased[COEF_Q_W-1:0];
  end
endmodule

// File: rtl/iqcal_coef_est.sv
module iqcal_coef_est
  import iqcal_pkg::*;
#(
  parameter int NCH   = 3,
  parameter int DW    = 32,
  parameter int CNT_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [NCH-1:0]         chain_mask,
  input  logic [CNT_W-1:0]       sample_target,
  input  logic                   meas_valid,
  input  logic [NCH*DW-1:0]      meas_pwr_i,
  input  logic [NCH*DW-1:0]      meas_pwr_q,
  input  logic [NCH*DW-1:0]      meas_corr,
  output logic                   busy,
  output logic                   done,
  output logic                   corr_en,
  output logic [NCH-1:0]         coef_upd,
  output logic [NCH*COEF_I_W-1:0] coef_i,
  output logic [NCH*COEF_Q_W-1:0] coef_q
);
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [DW-1:0] NEG_EDGE = {1'b1, {(DW-1){1'b0}}};

  est_state_t        state;
  logic [CH_W-1:0]   ch;
  logic [CNT_W-1:0]  cnt, target_q;
  logic [NCH-1:0]    mask_q;
  logic              acc_clr, acc_add;
  logic [DW-1:0]     sum_pi [NCH];
  logic [DW-1:0]     sum_pq [NCH];
  logic [DW-1:0]     sum_cr [NCH];

  logic [DW-1:0]     cur_pi, cur_pq, cur_cr, mag, den_i, den_q;
  logic              neg, chain_ok;
  logic [DW-1:0]     pi_hold, denq_hold, quot_i_q;
  logic              neg_q;

  logic              div_go, div_fin;
  logic [DW-1:0]     div_a, div_b, div_quot;
  logic [COEF_I_W-1:0] ci_new;
  logic [COEF_Q_W-1:0] cq_new;
  logic [COEF_I_W-1:0] ci_r [NCH];
  logic [COEF_Q_W-1:0] cq_r [NCH];

  assign acc_clr = (state == ST_IDLE) && start;
  assign acc_add = (state == ST_ACC) && meas_valid;

  iqcal_accum #(.NCH(NCH), .DW(DW)) accum_i (
    .clk(clk), .rst(rst), .clr(acc_clr), .add(acc_add),
    .in_pi(meas_pwr_i), .in_pq(meas_pwr_q), .in_cr(meas_corr),
    .sum_pi(sum_pi), .sum_pq(sum_pq), .sum_cr(sum_cr)
  );

  iqcal_div #(.W(DW)) div_i (
    .clk(clk), .rst(rst), .go(div_go), .dividend(div_a),
    .divisor(div_b), .quot(div_quot), .fin(div_fin)
  );

  iqcal_coef_fmt #(.DW(DW)) fmt_i (
    .quot_i(quot_i_q), .quot_q(div_quot), .neg(neg_q),
    .ci(ci_new), .cq(cq_new)
  );

  // Per-chain statistics selection, sign folding and denominators
  always_comb begin
    cur_pi   = sum_pi[ch];
    cur_pq   = sum_pq[ch];
    cur_cr   = sum_cr[ch];
    neg      = cur_cr > NEG_EDGE;
    mag      = neg ? (~cur_cr + 1'b1) : cur_cr;
    den_i    = ((cur_pi >> 1) + (cur_pq >> 1)) >> DEN_I_SHIFT;
    den_q    = cur_pq >> DEN_Q_SHIFT;
    chain_ok = (cur_pq != '0) && (den_i != '0) && (den_q != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ch        <= '0;
      cnt       <= '0;
      target_q  <= '0;
      mask_q    <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      corr_en   <= 1'b0;
      coef_upd  <= '0;
      div_go    <= 1'b0;
      div_a     <= '0;
      div_b     <= '0;
      pi_hold   <= '0;
      denq_hold <= '0;
      quot_i_q  <= '0;
      neg_q     <= 1'b0;
    end else begin
      done   <= 1'b0;
      div_go <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            busy     <= 1'b1;
            corr_en  <= 1'b0;
            coef_upd <= '0;
            mask_q   <= chain_mask;
            target_q <= sample_target;
            cnt      <= '0;
            ch       <= '0;
            state    <= (sample_target == '0) ? ST_SETUP : ST_ACC;
          end
        end
        ST_ACC: begin
          if (meas_valid) begin
            cnt <= cnt + 1'b1;
            if ({1'b0, cnt} + 1'b1 >= {1'b0, target_q})
              state <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (mask_q[ch] && chain_ok) begin
            div_go    <= 1'b1;
            div_a     <= mag;
            div_b     <= den_i;
            neg_q     <= neg;
            pi_hold   <= cur_pi;
            denq_hold <= den_q;
            state     <= ST_DIV_I;
          end else if (ch == CH_W'(NCH-1)) begin
            state <= ST_FIN;
          end else begin
            ch <= ch + 1'b1;
          end
        end
        ST_DIV_I: begin
          if (div_fin) begin
            quot_i_q <= div_quot;
            div_go   <= 1'b1;
            div_a    <= pi_hold;
            div_b    <= denq_hold;
            state    <= ST_DIV_Q;
          end
        end
        ST_DIV_Q: begin
          if (div_fin) begin
            coef_upd[ch] <= 1'b1;
            if (ch == CH_W'(NCH-1)) begin
              state <= ST_FIN;
            end else begin
              ch    <= ch + 1'b1;
              state <= ST_SETUP;
            end
          end
        end
        ST_FIN: begin
          busy    <= 1'b0;
          done    <= 1'b1;
          corr_en <= 1'b1;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Coefficient storage, one write port per chain
  for (genvar c = 0; c < NCH; c++) begin : g_coef
    always_ff @(posedge clk) begin
      if (rst) begin
        ci_r[c] <= '0;
        cq_r[c] <= '0;
      end else if ((state == ST_DIV_Q) && div_fin && (ch == CH_W'(c))) begin
        ci_r[c] <= ci_new;
        cq_r[c] <= cq_new;
      end
    end
    assign coef_i[c*COEF_I_W +: COEF_I_W] = ci_r[c];
    assign coef_q[c*COEF_Q_W +: COEF_Q_W] = cq_r[c];
  end
endmodule

// File: rtl/iqcal_coef_est_chk.sv
module iqcal_coef_est_chk #(
  parameter int NCH = 3,
  parameter int CIW = 18,
  parameter int CQW = 15
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic           corr_en,
  input logic [NCH-1:0] coef_upd,
  input logic [CIW-1:0] coef_i,
  input logic [CQW-1:0] coef_q
);
  // R9
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R9
  busy_end_done_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R8
  en_off_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !corr_en);

  // R8
  en_rise_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(corr_en) |-> done);

  // R10
  upd_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !start |=> ((~coef_upd & $past(coef_upd)) == '0));

  // R11
  coef_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |=> ($stable(coef_i) && $stable(coef_q)));
endmodule

bind iqcal_coef_est iqcal_coef_est_chk #(
  .NCH(NCH), .CIW(NCH*6), .CQW(NCH*5)
) chk_i (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .corr_en(corr_en), .coef_upd(coef_upd), .coef_i(coef_i), .coef_q(coef_q)
);

// File: tb/iqcal_coef_est_tb_top.sv
`timescale 1ns/1ps
module iqcal_coef_est_tb_top;
  localparam int NCH = 3;
  localparam int DW  = 32;
  localparam int CW  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [NCH-1:0] chain_mask = '0;
  logic [CW-1:0] sample_target = '0;
  logic meas_valid = 1'b0;
  logic [NCH*DW-1:0] meas_pwr_i = '0, meas_pwr_q = '0, meas_corr = '0;
  logic busy, done, corr_en;
  logic [NCH-1:0] coef_upd;
  logic [NCH*6-1:0] coef_i;
  logic [NCH*5-1:0] coef_q;

  int checks = 0;
  int errors = 0;
  logic [5:0] exp_ci [NCH];
  logic [4:0] exp_cq [NCH];
  logic [NCH-1:0] exp_upd;
  logic [31:0] v_pi [NCH];
  logic [31:0] v_pq [NCH];
  logic [31:0] v_cr [NCH];

  always #2 clk = ~clk;

  iqcal_coef_est #(.NCH(NCH), .DW(DW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst), .start(start), .chain_mask(chain_mask),
    .sample_target(sample_target), .meas_valid(meas_valid),
    .meas_pwr_i(meas_pwr_i), .meas_pwr_q(meas_pwr_q), .meas_corr(meas_corr),
    .busy(busy), .done(done), .corr_en(corr_en), .coef_upd(coef_upd),
    .coef_i(coef_i), .coef_q(coef_q)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Reference computation from the requirements (R2, R3, R4, R5, R6)
  task automatic model(input logic [31:0] spi, input logic [31:0] spq,
                       input logic [31:0] scr, output bit ok,
                       output logic [5:0] ci, output logic [4:0] cq);
    logic [31:0] mag, di, dq, qi, qq;
    bit neg;
    longint qs;
    neg = scr > 32'h8000_0000;
    mag = neg ? (32'h0 - scr) : scr;
    di  = ((spi >> 1) + (spq >> 1)) >> 7;
    dq  = spq >> 6;
    ok  = (spq != 0) && (di != 0) && (dq != 0);
    ci  = '0;
    cq  = '0;
    if (ok) begin
      qi = mag / di;
      ci = neg ? qi[5:0] : 6'(7'd64 - {1'b0, qi[5:0]});
      qq = spi / dq;
      qs = longint'(qq) - 64;
      if (qs > 15) qs = 15;
      else if (qs < -16) qs = -16;
      cq = qs[4:0];
    end
  endtask

  task automatic run(input string name, input logic [NCH-1:0] mask,
                     input int unsigned n);
    int w;
    int done_cycles;
    @(negedge clk);
    chain_mask    = mask;
    sample_target = CW'(n);
    start         = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R9: busy one edge after start; R8: enable cleared
    chk(busy == 1'b1, "R9", {name, " busy after start"}, busy, 1);
    chk(corr_en == 1'b0, "R8", {name, " corr_en cleared"}, corr_en, 0);
    exp_upd = '0;
    for (int r = 0; r < int'(n); r++) begin
      for (int c = 0; c < NCH; c++) begin
        meas_pwr_i[c*DW +: DW] = v_pi[c];
        meas_pwr_q[c*DW +: DW] = v_pq[c];
        meas_corr[c*DW +: DW]  = v_cr[c];
      end
      meas_valid = 1'b1;
      @(negedge clk);
      meas_valid = 1'b0;
      @(negedge clk);
    end
    // Extra valid rounds must be ignored (R1)
    meas_valid = 1'b1;
    @(negedge clk);
    meas_valid = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      bit ok;
      logic [5:0] ci;
      logic [4:0] cq;
      model(32'(v_pi[c] * n), 32'(v_pq[c] * n), 32'(v_cr[c] * n), ok, ci, cq);
      if (mask[c] && ok) begin
        exp_ci[c] = ci;
        exp_cq[c] = cq;
        exp_upd[c] = 1'b1;
      end
    end
    w = 0;
    while (!done && w < 2000) begin
      @(negedge clk);
      w++;
    end
    chk(w < 2000, "R9", {name, " done within bound"}, w, 2000);
    done_cycles = done ? 1 : 0;
    chk(busy == 1'b0, "R9", {name, " busy low at done"}, busy, 0);
    chk(corr_en == 1'b1, "R8", {name, " corr_en at done"}, corr_en, 1);
    chk(coef_upd == exp_upd, "R10", {name, " updated flags (R7 R4)"},
        coef_upd, exp_upd);
    for (int c = 0; c < NCH; c++) begin
      chk(coef_i[c*6 +: 6] == exp_ci[c], "R5",
          $sformatf("%s I coef chain %0d (R1 R2 R3 R7)", name, c),
          coef_i[c*6 +: 6], exp_ci[c]);
      chk(coef_q[c*5 +: 5] == exp_cq[c], "R6",
          $sformatf("%s Q coef chain %0d (R3 R7)", name, c),
          coef_q[c*5 +: 5], exp_cq[c]);
    end
    @(negedge clk);
    if (done) done_cycles++;
    chk(done_cycles == 1, "R9", {name, " done single pulse"}, done_cycles, 1);
    // R11: idle outputs hold
    repeat (3) @(negedge clk);
    for (int c = 0; c < NCH; c++)
      chk(coef_i[c*6 +: 6] == exp_ci[c] && coef_q[c*5 +: 5] == exp_cq[c],
          "R11", $sformatf("%s hold chain %0d", name, c),
          {coef_i[c*6 +: 6], coef_q[c*5 +: 5]}, {exp_ci[c], exp_cq[c]});
  endtask

  task automatic t_reset();
    chk(busy == 0 && done == 0, "R9", "reset busy/done", {busy, done}, 0);
    chk(corr_en == 0, "R8", "reset corr_en", corr_en, 0);
    chk(coef_upd == 0, "R10", "reset flags", coef_upd, 0);
    chk(coef_i == 0 && coef_q == 0, "R11", "reset coefs", coef_i, 0);
  endtask

  task automatic t_all_chains();
    v_pi[0] = 1000000; v_pq[0] = 900000;  v_cr[0] = 20000;
    v_pi[1] = 800000;  v_pq[1] = 850000;  v_cr[1] = 32'hFFFF_8AD0;
    v_pi[2] = 4000000; v_pq[2] = 1000000; v_cr[2] = 5000;
    run("all_chains", 3'b111, 4);
  endtask

  task automatic t_single_chain();
    v_pi[0] = 5;      v_pq[0] = 77777777; v_cr[0] = 99;
    v_pi[1] = 100000; v_pq[1] = 1000000;  v_cr[1] = 32'hFFFF_E4A8;
    v_pi[2] = 3;      v_pq[2] = 55555555; v_cr[2] = 7;
    run("mask_one", 3'b010, 2);
  endtask

  task automatic t_skip_and_edge();
    v_pi[0] = 100;       v_pq[0] = 100;       v_cr[0] = 3;
    v_pi[1] = 500000;    v_pq[1] = 0;         v_cr[1] = 1;
    v_pi[2] = 300000000; v_pq[2] = 300000000; v_cr[2] = 32'h8000_0000;
    run("skip_edge", 3'b111, 1);
  endtask

  task automatic t_zero_target();
    run("zero_target", 3'b111, 0);
  endtask

  task automatic t_wrap();
    v_pi[0] = 32'hA000_0000; v_pq[0] = 32'h6000_0000; v_cr[0] = 32'h100;
    v_pi[1] = 1;             v_pq[1] = 1;             v_cr[1] = 1;
    v_pi[2] = 123456;        v_pq[2] = 234567;        v_cr[2] = 32'hFFFF_D8F1;
    run("wrap", 3'b101, 3);
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin
      exp_ci[c] = '0;
      exp_cq[c] = '0;
    end
    exp_upd = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_all_chains();
    t_single_chain();
    t_skip_and_edge();
    t_zero_target();
    t_wrap();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule